// File: doc/BRIEF.md
# Write Atomicity Acknowledgement Gate

This block sits beside one memory line at the home side of a shared-memory system with `NPROC` processors. It makes a write to that line atomic as seen by all processors. When it takes a write, it sends an invalidate or update message to every processor except the writer. It then collects their acknowledgements in a bitmask and holds back every read of the line until the mask is full. Only one write can be in flight at a time, so all processors see writes to the line in one order.

In invalidate mode the line reopens in the cycle after the last acknowledgement arrives. In update mode the block first sends a completion broadcast to every processor, writer included. The line reopens in the cycle after that broadcast, and no processor's read enable returns before it. Reads that arrive while the line is closed are queued and answered one per cycle, in arrival order, once the line reopens.

Top module: `wag_gate`

## Requirements
- R1: After reset, `wr_ready` is 1, `rd_ready` is 1, `rd_en` is all ones, and `msg_valid` and `rsp_valid` are 0.
- R2: In the cycle after a write is accepted, `msg_valid` is raised for exactly one cycle toward every processor except the writer (`wr_src`). `msg_kind` is 1 for invalidate (`mode_update`=0) and 2 for update (`mode_update`=1). The mode is sampled only when the write is accepted.
- R3: While acknowledgements are being collected, an `ack` bit counts only if it comes from a processor other than the writer. Repeated acks and acks from the writer have no effect. The write completes in the cycle in which the last missing ack arrives, which may be the same cycle as the message.
- R4: From the cycle after a write is accepted until the line reopens, `wr_ready` is 0, and a pending write waits.
- R5: In invalidate mode, `rd_en` is all zeros from the cycle after acceptance through the completion cycle. It is all ones again in the cycle after completion.
- R6: In update mode, the cycle after completion carries `msg_valid` all ones with `msg_kind`=3, and `rd_en` is still all zeros in that cycle. `rd_en` returns to all ones in the cycle after.
- R7: A read request taken when `rd_ready`=1 is answered by a one-cycle `rsp_valid` pulse with `rsp_dst` equal to its `rd_src`. The answer comes no earlier than the next cycle and only while the line is open. Answers come one per cycle, in arrival order.
- R8: A write is accepted only while at most one read is queued. A read taken in the same cycle as a write, or after it, is answered only after that write completes.
- R9: The read queue holds `RQ_DEPTH` requests; with the queue full, `rd_ready` is 0 and a read offered then is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode_update | input | 1 | 1 = update protocol, 0 = invalidate; sampled with the write |
| wr_valid | input | 1 | Write request |
| wr_src | input | IDW | Writing processor |
| wr_ready | output | 1 | Write can be accepted this cycle |
| rd_valid | input | 1 | Read request |
| rd_src | input | IDW | Reading processor |
| rd_ready | output | 1 | Read queue has room |
| rsp_valid | output | 1 | Read answered this cycle |
| rsp_dst | output | IDW | Processor the answer goes to |
| msg_valid | output | NPROC | Per-processor message strobe |
| msg_kind | output | 2 | 1 invalidate, 2 update, 3 completion |
| ack | input | NPROC | Per-processor acknowledgement |
| rd_en | output | NPROC | Per-processor permission to read the line |

## Verification
The bench sweeps both modes, every writer, and three ack orders: ascending, descending, and all at once in the message cycle. The writer's own ack and repeated acks are mixed in. A design that counted those stray acks would reopen the line early, and the bench sees this as `rd_en` rising before the final ack. In update mode, a design that skipped the completion broadcast, or raised `rd_en` in the same cycle as it, fails the cycle-exact checks. The bench also flips `mode_update` after acceptance, which catches a design that samples the mode late.

Two stress cases target the read queue. The first fills the queue while a write is pending, offers one read too many, and parks a second write. A correct design then answers the eight reads in order and takes the parked write only when one read is left. A design that took it earlier would show a message in the wrong cycle. The second case offers a read and a write in the same cycle: a design that served that read before the write completed would answer it too soon.

// File: rtl/wag_gate.sv
module wag_gate #(
  parameter int NPROC    = 4,
  parameter int RQ_DEPTH = 8,
  localparam int IDW = (NPROC > 1) ? $clog2(NPROC) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             mode_update,
  input  logic             wr_valid,
  input  logic [IDW-1:0]   wr_src,
  output logic             wr_ready,
  input  logic             rd_valid,
  input  logic [IDW-1:0]   rd_src,
  output logic             rd_ready,
  output logic             rsp_valid,
  output logic [IDW-1:0]   rsp_dst,
  output logic [NPROC-1:0] msg_valid,
  output logic [1:0]       msg_kind,
  input  logic [NPROC-1:0] ack,
  output logic [NPROC-1:0] rd_en
);

  localparam int PW = (RQ_DEPTH > 1) ? $clog2(RQ_DEPTH) : 1;
  localparam int CW = $clog2(RQ_DEPTH + 1);
  localparam logic [NPROC-1:0] ALL = {NPROC{1'b1}};
  localparam logic [1:0] K_INV = 2'd1, K_UPD = 2'd2, K_DONE = 2'd3;

  typedef enum logic [1:0] {S_IDLE, S_COLL, S_BCAST} st_t;

  st_t              state;
  logic             mode_q;
  logic [IDW-1:0]   wid_q;
  logic [NPROC-1:0] need_q, got_q;
  logic [IDW-1:0]   rq [RQ_DEPTH];
  logic [PW-1:0]    rp, wp;
  logic [CW-1:0]    cnt;

  logic             idle, wr_acc, rd_acc, done;
  logic [NPROC-1:0] oh_src, ack_ok, got_nx;

  assign idle      = (state == S_IDLE);
  assign oh_src    = NPROC'(1) << wr_src;
  assign wr_ready  = idle && (cnt <= CW'(1));
  assign wr_acc    = wr_valid && wr_ready;
  assign rd_ready  = (cnt < CW'(RQ_DEPTH));
  assign rd_acc    = rd_valid && rd_ready;
  assign rsp_valid = idle && (cnt != '0);
  assign rsp_dst   = rq[rp];
  assign rd_en     = {NPROC{idle}};
  assign ack_ok    = ack & need_q & {NPROC{state == S_COLL}};
  assign got_nx    = got_q | ack_ok;
  assign done      = (state == S_COLL) && (got_nx == need_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state     <= S_IDLE;
      mode_q    <= 1'b0;
      wid_q     <= '0;
      need_q    <= '0;
      got_q     <= '0;
      msg_valid <= '0;
      msg_kind  <= '0;
    end else begin
      msg_valid <= '0;
      msg_kind  <= '0;
      case (state)
        S_IDLE: if (wr_acc) begin
          state     <= S_COLL;
          need_q    <= ~oh_src;
          got_q     <= '0;
          mode_q    <= mode_update;
          wid_q     <= wr_src;
          msg_valid <= ~oh_src;
          msg_kind  <= mode_update ? K_UPD : K_INV;
        end
        S_COLL: begin
          got_q <= got_nx;
          if (done) begin
            if (mode_q) begin
              state     <= S_BCAST;
              msg_valid <= ALL;
              msg_kind  <= K_DONE;
            end else begin
              state <= S_IDLE;
            end
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rp  <= '0;
      wp  <= '0;
      cnt <= '0;
    end else begin
      if (rd_acc) begin
        rq[wp] <= rd_src;
        wp     <= (wp == PW'(RQ_DEPTH - 1)) ? '0 : wp + PW'(1);
      end
      if (rsp_valid)
        rp <= (rp == PW'(RQ_DEPTH - 1)) ? '0 : rp + PW'(1);
      cnt <= cnt + CW'(rd_acc) - CW'(rsp_valid);
    end
  end

  a_r2_msg_skips_writer: assert property (@(posedge clk) disable iff (!rst_n)
    (msg_kind == K_INV || msg_kind == K_UPD) |->
      (!msg_valid[wid_q] && $countones(msg_valid) == NPROC - 1));

  a_r2_msg_single_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    (msg_kind == K_INV || msg_kind == K_UPD) |=> !(msg_kind == K_INV || msg_kind == K_UPD));

  a_r3_got_within_need: assert property (@(posedge clk) disable iff (!rst_n)
    (got_q & ~need_q) == '0);

  a_r4_stall_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
    wr_acc |=> !wr_ready);

  a_r5_reopen_after_done: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !mode_q) |=> (rd_en == ALL));

  a_r6_bcast_follows_collect: assert property (@(posedge clk) disable iff (!rst_n)
    (msg_kind == K_DONE) |-> ($past(state == S_COLL) && mode_q && msg_valid == ALL && rd_en == '0));

  a_r7_answer_when_open: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> (rd_en == ALL));

  a_r9_queue_bound: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CW'(RQ_DEPTH));

endmodule

// File: tb/sim_wag_gate.sv
module sim_wag_gate;
  localparam int CLK_PERIOD = 10;
  localparam int NP = 4;
  localparam int DEPTH = 8;

  logic clk = 0, rst_n = 0;
  logic mode_update = 0, wr_valid = 0, rd_valid = 0;
  logic [1:0] wr_src = 0, rd_src = 0;
  logic wr_ready, rd_ready, rsp_valid;
  logic [1:0] rsp_dst, msg_kind;
  logic [NP-1:0] msg_valid, ack = 0, rd_en;

  int checks = 0, errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  wag_gate #(.NPROC(NP), .RQ_DEPTH(DEPTH)) u0 (
    .clk(clk), .rst_n(rst_n), .mode_update(mode_update),
    .wr_valid(wr_valid), .wr_src(wr_src), .wr_ready(wr_ready),
    .rd_valid(rd_valid), .rd_src(rd_src), .rd_ready(rd_ready),
    .rsp_valid(rsp_valid), .rsp_dst(rsp_dst),
    .msg_valid(msg_valid), .msg_kind(msg_kind),
    .ack(ack), .rd_en(rd_en));

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
    end
  endtask

  task automatic tick;
    @(posedge clk); #1;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog act=0 exp=1");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int lst[3];
    int n;
    int others;
    int reader;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1;
    #1;
    chk("R1 wr_ready", wr_ready, 1);
    chk("R1 rd_ready", rd_ready, 1);
    chk("R1 rd_en", rd_en, 15);
    chk("R1 msg_valid", msg_valid, 0);
    chk("R1 rsp_valid", rsp_valid, 0);

    // R7: reads on an open line, answered next cycle in order
    for (int i = 0; i < 3; i++) begin
      @(negedge clk) begin rd_valid = 1; rd_src = 2'((i + 2) % 4); end
      tick();
      chk("R7 idle rsp_valid", rsp_valid, 1);
      chk("R7 idle rsp_dst", rsp_dst, (i + 2) % 4);
    end
    @(negedge clk) rd_valid = 0;
    tick();
    chk("R7 single answer", rsp_valid, 0);

    // Sweep: mode x writer x ack pattern (R2 R3 R4 R5 R6 R7)
    for (int mode = 0; mode < 2; mode++)
      for (int w = 0; w < NP; w++)
        for (int pat = 0; pat < 3; pat++) begin
          others = 15 & ~(1 << w);
          reader = (w + 1) % NP;
          n = 0;
          for (int p = 0; p < NP; p++) if (p != w) begin lst[n] = p; n++; end
          if (pat == 1) begin int t; t = lst[0]; lst[0] = lst[2]; lst[2] = t; end

          @(negedge clk) begin wr_valid = 1; wr_src = 2'(w); mode_update = 1'(mode); end
          #1 chk("R4 ready when open", wr_ready, 1);
          tick();
          chk("R2 msg mask", msg_valid, others);
          chk("R2 msg kind", msg_kind, mode ? 2 : 1);
          chk("R4 stall", wr_ready, 0);
          chk("R5 rd_en closed", rd_en, 0);

          @(negedge clk) begin
            wr_valid = 0; mode_update = ~1'(mode);
            rd_valid = 1; rd_src = 2'(reader);
            ack = (pat == 2) ? 4'hF : 4'(1 << w);
          end
          tick();
          if (pat != 2) begin
            chk("R3 writer ack ignored rd_en", rd_en, 0);
            chk("R3 writer ack ignored msg", msg_valid, 0);
            chk("R7 held", rsp_valid, 0);
            for (int k = 0; k < 3; k++) begin
              @(negedge clk) begin
                rd_valid = 0;
                ack = 4'(1 << lst[k]);
                if (k > 0) ack = ack | 4'(1 << lst[k-1]);
              end
              tick();
              if (k < 2) begin
                chk("R3 partial acks hold rd_en", rd_en, 0);
                chk("R3 partial acks hold rsp", rsp_valid, 0);
                chk("R4 partial acks stall", wr_ready, 0);
              end
            end
          end
          if (mode == 0) begin
            chk("R5 reopen", rd_en, 15);
            chk("R5 no bcast", msg_valid, 0);
            chk("R7 held read answered", rsp_valid, 1);
            chk("R7 held read dst", rsp_dst, reader);
          end else begin
            chk("R6 bcast mask", msg_valid, 15);
            chk("R6 bcast kind", msg_kind, 3);
            chk("R6 rd_en closed in bcast", rd_en, 0);
            chk("R6 no answer in bcast", rsp_valid, 0);
            @(negedge clk) begin ack = 0; rd_valid = 0; end
            tick();
            chk("R6 reopen", rd_en, 15);
            chk("R6 bcast one cycle", msg_valid, 0);
            chk("R7 held read answered", rsp_valid, 1);
            chk("R7 held read dst", rsp_dst, reader);
          end
          @(negedge clk) begin ack = 0; rd_valid = 0; end
          tick();
          chk("R7 one answer", rsp_valid, 0);
          chk("R4 open again", wr_ready, 1);
        end

    // R9 / R8: fill the queue while busy, park a second write
    @(negedge clk) begin wr_valid = 1; wr_src = 0; mode_update = 0; end
    tick();
    @(negedge clk) wr_valid = 0;
    for (int i = 0; i < DEPTH + 1; i++) begin
      @(negedge clk) begin rd_valid = 1; rd_src = 2'(i % 4); end
      #1 chk("R9 rd_ready", rd_ready, (i < DEPTH) ? 1 : 0);
      tick();
    end
    @(negedge clk) begin rd_valid = 0; wr_valid = 1; wr_src = 2; ack = 4'hE; end
    #1 chk("R4 parked write stalled", wr_ready, 0);
    tick();
    @(negedge clk) ack = 0;
    for (int k = 0; k < DEPTH; k++) begin
      chk("R7 queued answer", rsp_valid, 1);
      chk("R7 queued order", rsp_dst, k % 4);
      chk("R8 write waits for queue", wr_ready, (k == DEPTH - 1) ? 1 : 0);
      tick();
    end
    chk("R9 overflow read dropped", rsp_valid, 0);
    chk("R8 parked write msg", msg_valid, 4'b1011);
    chk("R8 parked write kind", msg_kind, 1);
    @(negedge clk) begin wr_valid = 0; ack = 4'hF; end
    tick();
    chk("R5 reopen after parked write", rd_en, 15);
    @(negedge clk) ack = 0;

    // R8: read in the same cycle as a write
    @(negedge clk) begin wr_valid = 1; wr_src = 1; rd_valid = 1; rd_src = 3; end
    tick();
    chk("R8 same-cycle read held", rsp_valid, 0);
    @(negedge clk) begin wr_valid = 0; rd_valid = 0; ack = 4'hD; end
    tick();
    chk("R8 same-cycle read answered", rsp_valid, 1);
    chk("R8 same-cycle read dst", rsp_dst, 3);
    @(negedge clk) ack = 0;
    tick();
    chk("R8 queue drained", rsp_valid, 0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule